// File: doc/BRIEF.md
# Core Migration Phase Sequencer

This block moves one running thread around a ring of identical cores. A migration starts in one of two ways. The first is a programmable cycle interval that counts while the cluster is settled. The second is an external request. The block then picks the next core in the ring as its target and powers it up while the current core keeps executing. It can optionally open a window in which the target's predictor is trained from branches the source commits. It then flushes the source pipeline and runs the correctness-update phase. In that phase the source's dirty private-cache lines are written back and the architectural registers are streamed to the target. Finally it hands execution to the target.

The two update activities can overlap, or they can run back to back with writeback first, so the register move can go through shared memory without a dedicated bus. The length of the training window is a power-of-two fraction of the effective interval. Writeback completion comes from the cache side as a done signal. Cache, predictor and core internals are outside the block. It only produces the per-core control strobes and the register-transfer indices.

Top module: `mig_seq`

## Requirements
- R1: After reset, core 0 is the only core with run enable, `active_core` is 0, `busy` is low, and no activate, train, flush, writeback-request or register-valid strobe is high.
- R2: The target is always (active_core + 1) mod N_CORES, so core N_CORES-1 hands over to core 0. In the first busy cycle `core_activate` is the one-hot of that target.
- R3: With `interval_en` high, a migration starts after the block has been idle for max(`interval_len`, INIT_CYC+1) cycles. An `ext_req` seen in an idle cycle starts a migration in the next cycle.
- R4: A trigger (request or interval) that arrives while `busy` is high does not start another migration. After the handover the block stays idle and the core has advanced by exactly one step.
- R5: The initialization phase lasts exactly INIT_CYC cycles. The target's activate strobe is high throughout, and the source keeps its run enable.
- R6: With `train_frac` = 1, 2 or 3, the training phase lasts max(E >> (4 - train_frac), 1) cycles, where E is the effective interval of R3. Only the target's train strobe is high, and the source keeps running. With `train_frac` = 0 no training phase occurs.
- R7: The source's flush strobe is high for exactly one cycle, directly after initialization or training. From that cycle on, no core has run enable until the handover.
- R8: Each migration streams exactly REG_COUNT register-valid cycles with indices 0, 1, ... REG_COUNT-1 in consecutive cycles. They come after REG_SETUP setup cycles, with `reg_src`/`reg_dst` equal to the source and target.
- R9: With `serial_mode` low, the register stream and the writeback request start in the first update cycle. The phase ends in the first cycle in which both are finished.
- R10: With `serial_mode` high, no register-valid cycle occurs while the writeback request is outstanding. Setup starts in the cycle after writeback completes.
- R11: `core_wb_req` of the source stays high until the first cycle in which `wb_done` is seen. When `wb_done` is already high in the first update cycle (no dirty lines), the request lasts one cycle.
- R12: In the first cycle after the update phase, `active_core` equals the target, only the target has run enable, and no activate strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| interval_en | input | 1 | Enable the periodic migration timer |
| interval_len | input | CNT_W | Migration interval in cycles (clamped to at least INIT_CYC+1) |
| ext_req | input | 1 | External migration request |
| train_frac | input | 2 | Training window: 0 off, 1 = E/8, 2 = E/4, 3 = E/2 |
| serial_mode | input | 1 | 1: writeback then register stream; 0: both together |
| wb_done | input | 1 | Cache side reports that the dirty-line writeback is complete |
| busy | output | 1 | A migration is in progress |
| active_core | output | CORE_W | Index of the core that owns the thread |
| core_run | output | N_CORES | Per-core run enable |
| core_activate | output | N_CORES | Per-core power-up / activation request |
| core_train | output | N_CORES | Per-core predictor training window |
| core_flush | output | N_CORES | Per-core pipeline flush strobe |
| core_wb_req | output | N_CORES | Per-core dirty-line writeback request |
| reg_xfer_valid | output | 1 | A register index is being transferred this cycle |
| reg_xfer_idx | output | RIDX_W | Architectural register index being moved |
| reg_src | output | CORE_W | Core the registers are read from |
| reg_dst | output | CORE_W | Core the registers are written to |

## Verification
A corrupted phase counter shows up at the strobe ports within one phase. The init or training window then runs a cycle long or short, or the flush pulse lasts more than one cycle, and the bench measures these lengths sample by sample. A corrupted register-stream counter shows up as a skipped or repeated index, or a valid count other than REG_COUNT, before the handover. A wrong core index is visible in the first busy cycle on `core_activate` and in the first idle cycle on `active_core` and `core_run`. A broken trigger gate shows up as an idle stretch of the wrong length or as a second migration after the handover.

// File: rtl/mig_pkg.sv
package mig_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_INIT,
        PH_TRAIN,
        PH_FLUSH,
        PH_UPDATE
    } mig_phase_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_SETUP,
        RS_SEND,
        RS_DONE
    } rs_state_e;

    // Phases in which the source still executes
    function automatic logic phase_src_runs(mig_phase_e ph);
        return (ph == PH_IDLE) || (ph == PH_INIT) || (ph == PH_TRAIN);
    endfunction

    // Phases in which the target is powered on its way in
    function automatic logic phase_tgt_powered(mig_phase_e ph);
        return (ph == PH_INIT) || (ph == PH_TRAIN) || (ph == PH_FLUSH) || (ph == PH_UPDATE);
    endfunction

endpackage

// File: rtl/mig_interval_timer.sv
module mig_interval_timer #(
    parameter int CNT_W    = 24,
    parameter int MIN_SPAN = 1001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idle,
    input  logic             interval_en,
    input  logic [CNT_W-1:0] interval_len,
    input  logic             ext_req,
    output logic             fire,
    output logic [CNT_W-1:0] eff_span
);

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_SPAN);

    logic [CNT_W-1:0] cnt;

    assign eff_span = (interval_len < MIN_V) ? MIN_V : interval_len;
    assign fire     = idle && (ext_req || (interval_en && (cnt == eff_span - CNT_W'(1))));

    always_ff @(posedge clk) begin
        if (rst || !idle || !interval_en || fire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mig_reg_streamer.sv
module mig_reg_streamer
    import mig_pkg::*;
#(
    parameter int SETUP = 30,
    parameter int COUNT = 70,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic             done
);

    localparam int SPAN = (SETUP > COUNT) ? SETUP : COUNT;
    localparam int CW   = $clog2(SPAN + 1);

    rs_state_e      st;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            st  <= RS_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                RS_IDLE: begin
                    if (start) begin
                        st  <= (SETUP == 0) ? RS_SEND : RS_SETUP;
                        cnt <= '0;
                    end
                end
                RS_SETUP: begin
                    if (cnt == CW'(SETUP - 1)) begin
                        st  <= RS_SEND;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                RS_SEND: begin
                    if (cnt == CW'(COUNT - 1)) begin
                        st  <= RS_DONE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CW'(1);
                    end
                end
                default: st <= RS_DONE;
            endcase
        end
    end

    assign valid = (st == RS_SEND);
    assign idx   = IDX_W'(cnt);
    assign done  = (st == RS_DONE);

endmodule

// File: rtl/mig_core_lanes.sv
module mig_core_lanes
    import mig_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter int CORE_W  = 2
) (
    input  mig_phase_e          phase,
    input  logic [CORE_W-1:0]   cur,
    input  logic [CORE_W-1:0]   tgt,
    input  logic                wb_pending,
    output logic [N_CORES-1:0]  run,
    output logic [N_CORES-1:0]  activate,
    output logic [N_CORES-1:0]  train,
    output logic [N_CORES-1:0]  flush,
    output logic [N_CORES-1:0]  wb_req
);

    for (genvar i = 0; i < N_CORES; i++) begin : g_lane
        logic is_src;
        logic is_tgt;
        assign is_src      = (cur == CORE_W'(i));
        assign is_tgt      = (tgt == CORE_W'(i));
        assign run[i]      = is_src && phase_src_runs(phase);
        assign activate[i] = is_tgt && phase_tgt_powered(phase);
        assign train[i]    = is_tgt && (phase == PH_TRAIN);
        assign flush[i]    = is_src && (phase == PH_FLUSH);
        assign wb_req[i]   = is_src && (phase == PH_UPDATE) && wb_pending;
    end

endmodule

// File: rtl/mig_seq.sv
module mig_seq
    import mig_pkg::*;
#(
    parameter int N_CORES   = 4,
    parameter int INIT_CYC  = 1000,
    parameter int REG_SETUP = 30,
    parameter int REG_COUNT = 70,
    parameter int CNT_W     = 24,
    localparam int CORE_W   = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int RIDX_W   = $clog2(REG_COUNT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               interval_en,
    input  logic [CNT_W-1:0]   interval_len,
    input  logic               ext_req,
    input  logic [1:0]         train_frac,
    input  logic               serial_mode,
    input  logic               wb_done,
    output logic               busy,
    output logic [CORE_W-1:0]  active_core,
    output logic [N_CORES-1:0] core_run,
    output logic [N_CORES-1:0] core_activate,
    output logic [N_CORES-1:0] core_train,
    output logic [N_CORES-1:0] core_flush,
    output logic [N_CORES-1:0] core_wb_req,
    output logic               reg_xfer_valid,
    output logic [RIDX_W-1:0]  reg_xfer_idx,
    output logic [CORE_W-1:0]  reg_src,
    output logic [CORE_W-1:0]  reg_dst
);

    localparam logic [CNT_W-1:0]  INIT_LAST = CNT_W'(INIT_CYC - 1);
    localparam logic [CORE_W-1:0] LAST_CORE = CORE_W'(N_CORES - 1);

    mig_phase_e        phase;
    logic [CORE_W-1:0] cur;
    logic [CORE_W-1:0] tgt;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  tlen;
    logic              train_on;
    logic              wb_seen;

    logic              fire;
    logic [CNT_W-1:0]  eff_span;
    logic [CNT_W-1:0]  t_shift;
    logic [CNT_W-1:0]  t_span;
    logic [CORE_W-1:0] nxt;
    logic              in_update;
    logic              wb_fin;
    logic              rs_start;
    logic              rs_done;

    mig_interval_timer #(
        .CNT_W    (CNT_W),
        .MIN_SPAN (INIT_CYC + 1)
    ) u_timer (
        .clk          (clk),
        .rst          (rst),
        .idle         (phase == PH_IDLE),
        .interval_en  (interval_en),
        .interval_len (interval_len),
        .ext_req      (ext_req),
        .fire         (fire),
        .eff_span     (eff_span)
    );

    always_comb begin
        case (train_frac)
            2'd1:    t_shift = eff_span >> 3;
            2'd2:    t_shift = eff_span >> 2;
            default: t_shift = eff_span >> 1;
        endcase
        t_span = (t_shift == '0) ? CNT_W'(1) : t_shift;
    end

    assign nxt       = (cur == LAST_CORE) ? '0 : cur + CORE_W'(1);
    assign in_update = (phase == PH_UPDATE);
    assign wb_fin    = wb_seen || (in_update && wb_done);
    assign rs_start  = in_update && (!serial_mode || wb_fin);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cur      <= '0;
            tgt      <= '0;
            cnt      <= '0;
            tlen     <= '0;
            train_on <= 1'b0;
            wb_seen  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (fire) begin
                        phase    <= PH_INIT;
                        tgt      <= nxt;
                        cnt      <= '0;
                        tlen     <= t_span;
                        train_on <= (train_frac != 2'd0);
                    end
                end
                PH_INIT: begin
                    if (cnt == INIT_LAST) begin
                        cnt   <= '0;
                        phase <= train_on ? PH_TRAIN : PH_FLUSH;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_TRAIN: begin
                    if (cnt == tlen - CNT_W'(1)) begin
                        cnt   <= '0;
                        phase <= PH_FLUSH;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                PH_FLUSH: begin
                    phase   <= PH_UPDATE;
                    wb_seen <= 1'b0;
                end
                PH_UPDATE: begin
                    if (wb_done) begin
                        wb_seen <= 1'b1;
                    end
                    if (wb_fin && rs_done) begin
                        phase <= PH_IDLE;
                        cur   <= tgt;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    mig_reg_streamer #(
        .SETUP (REG_SETUP),
        .COUNT (REG_COUNT),
        .IDX_W (RIDX_W)
    ) u_stream (
        .clk   (clk),
        .rst   (rst),
        .clear (!in_update),
        .start (rs_start),
        .valid (reg_xfer_valid),
        .idx   (reg_xfer_idx),
        .done  (rs_done)
    );

    mig_core_lanes #(
        .N_CORES (N_CORES),
        .CORE_W  (CORE_W)
    ) u_lanes (
        .phase      (phase),
        .cur        (cur),
        .tgt        (tgt),
        .wb_pending (!wb_seen),
        .run        (core_run),
        .activate   (core_activate),
        .train      (core_train),
        .flush      (core_flush),
        .wb_req     (core_wb_req)
    );

    assign busy        = (phase != PH_IDLE);
    assign active_core = cur;
    assign reg_src     = cur;
    assign reg_dst     = tgt;

endmodule

// File: rtl/mig_seq_chk.sv
module mig_seq_chk #(
    parameter int N_CORES = 4,
    parameter int CORE_W  = 2,
    parameter int RIDX_W  = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               serial_mode,
    input logic               busy,
    input logic [CORE_W-1:0]  active_core,
    input logic [N_CORES-1:0] core_run,
    input logic [N_CORES-1:0] core_activate,
    input logic [N_CORES-1:0] core_train,
    input logic [N_CORES-1:0] core_flush,
    input logic [N_CORES-1:0] core_wb_req,
    input logic               reg_xfer_valid,
    input logic [RIDX_W-1:0]  reg_xfer_idx
);

    logic [N_CORES-1:0] nxt_hot;
    always_comb begin
        nxt_hot = '0;
        nxt_hot[(active_core == CORE_W'(N_CORES - 1)) ? '0 : active_core + CORE_W'(1)] = 1'b1;
    end

    p_run_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(core_run));

    p_core_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (active_core == $past(active_core)));

    p_ring_target_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (core_activate == nxt_hot));

    p_train_src_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (|core_train) |-> (|core_run));

    p_flush_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        (|core_flush) |=> !(|core_flush));

    p_stream_step_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_xfer_valid && $past(reg_xfer_valid)) |-> (reg_xfer_idx == $past(reg_xfer_idx) + RIDX_W'(1)));

    p_stream_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        reg_xfer_valid |-> (core_run == '0));

    p_serial_order_r10: assert property (@(posedge clk) disable iff (rst)
        (serial_mode && (|core_wb_req)) |-> !reg_xfer_valid);

endmodule

bind mig_seq mig_seq_chk #(
    .N_CORES (N_CORES),
    .CORE_W  (CORE_W),
    .RIDX_W  (RIDX_W)
) u_chk (.*);

// File: tb/tb_mig_seq.sv
module tb_mig_seq;

    localparam int N     = 3;
    localparam int INIT  = 6;
    localparam int SETUP = 3;
    localparam int COUNT = 5;
    localparam int CW    = 16;
    localparam int CORE_W = 2;
    localparam int RIDX_W = 3;

    typedef struct packed {
        logic        ext;
        logic [15:0] ilen;
        logic [1:0]  frac;
        logic        ser;
        logic [7:0]  wbd;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'd40, 2'd0, 1'b0, 8'd2},
        '{1'b0, 16'd3,  2'd2, 1'b1, 8'd4},
        '{1'b1, 16'd40, 2'd3, 1'b0, 8'd15},
        '{1'b0, 16'd64, 2'd1, 1'b1, 8'd0},
        '{1'b1, 16'd32, 2'd0, 1'b1, 8'd0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst;
    logic              interval_en;
    logic [CW-1:0]     interval_len;
    logic              ext_req;
    logic [1:0]        train_frac;
    logic              serial_mode;
    logic              wb_done;
    logic              busy;
    logic [CORE_W-1:0] active_core;
    logic [N-1:0]      core_run, core_activate, core_train, core_flush, core_wb_req;
    logic              reg_xfer_valid;
    logic [RIDX_W-1:0] reg_xfer_idx;
    logic [CORE_W-1:0] reg_src, reg_dst;

    mig_seq #(
        .N_CORES (N), .INIT_CYC (INIT), .REG_SETUP (SETUP), .REG_COUNT (COUNT), .CNT_W (CW)
    ) dut (
        .clk, .rst, .interval_en, .interval_len, .ext_req, .train_frac, .serial_mode, .wb_done,
        .busy, .active_core, .core_run, .core_activate, .core_train, .core_flush, .core_wb_req,
        .reg_xfer_valid, .reg_xfer_idx, .reg_src, .reg_dst
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic migrate(input vec_t v, input int src, input int tgt, input bit hold);
        int eff, exp_idle, exp_t, n, gap, vcnt, wreq, ulen, exp_gap, exp_len, sc;
        bit bad, ordbad, serbad, seen_v;
        eff = (int'(v.ilen) < INIT + 1) ? INIT + 1 : int'(v.ilen);
        exp_idle = v.ext ? 1 : eff;
        if (v.frac == 2'd0) exp_t = 0;
        else begin
            exp_t = eff >> (4 - int'(v.frac));
            if (exp_t == 0) exp_t = 1;
        end
        serial_mode  = v.ser;
        train_frac   = v.frac;
        interval_len = v.ilen;
        interval_en  = !v.ext;
        ext_req      = v.ext;
        n = 0;
        while (!busy) begin n++; @(negedge clk); end
        interval_en = 1'b0;
        if (!hold) ext_req = 1'b0;
        chk(n == exp_idle, "R3 idle cycles before trigger", n, exp_idle);
        chk(core_activate == N'(1 << tgt), "R2 ring target activate", int'(core_activate), 1 << tgt);
        n = 0; bad = 0;
        while (core_train == '0 && core_flush == '0) begin
            if (core_run != N'(1 << src) || core_activate != N'(1 << tgt)) bad = 1;
            n++; @(negedge clk);
        end
        chk(n == INIT, "R5 init length", n, INIT);
        chk(!bad, "R5 source runs during init", int'(bad), 0);
        n = 0; bad = 0;
        while (core_train != '0) begin
            if (core_train != N'(1 << tgt) || core_run != N'(1 << src)) bad = 1;
            n++; @(negedge clk);
        end
        chk(n == exp_t, "R6 training length", n, exp_t);
        chk(!bad, "R6 training strobes", int'(bad), 0);
        chk(core_flush == N'(1 << src) && core_run == '0, "R7 flush source", int'(core_flush), 1 << src);
        @(negedge clk);
        chk(core_flush == '0, "R7 flush one cycle", int'(core_flush), 0);
        gap = 0; vcnt = 0; wreq = 0; ulen = 0; ordbad = 0; serbad = 0; seen_v = 0;
        while (busy) begin
            ulen++;
            if (core_run != '0) ordbad = 1;
            if (core_wb_req != '0) begin
                wreq++;
                if (core_wb_req != N'(1 << src)) ordbad = 1;
                if (wreq >= int'(v.wbd) + 1) wb_done = 1'b1;
                if (v.ser && reg_xfer_valid) serbad = 1;
            end else begin
                wb_done = 1'b0;
            end
            if (reg_xfer_valid) begin
                if (int'(reg_xfer_idx) != vcnt || int'(reg_src) != src || int'(reg_dst) != tgt) ordbad = 1;
                vcnt++; seen_v = 1;
            end else if (!seen_v) begin
                gap++;
            end
            @(negedge clk);
        end
        wb_done = 1'b0;
        sc = SETUP + COUNT + 1;
        if (v.ser) begin
            exp_gap = int'(v.wbd) + SETUP + 1;
            exp_len = int'(v.wbd) + sc + 1;
        end else begin
            exp_gap = SETUP + 1;
            exp_len = ((int'(v.wbd) > sc) ? int'(v.wbd) : sc) + 1;
        end
        chk(wreq == int'(v.wbd) + 1, "R11 writeback request length", wreq, int'(v.wbd) + 1);
        chk(vcnt == COUNT, "R8 register count", vcnt, COUNT);
        chk(!ordbad, "R8 register order and cores", int'(ordbad), 0);
        if (v.ser) begin
            chk(!serbad, "R10 no register before writeback", int'(serbad), 0);
            chk(gap == exp_gap, "R10 serial setup start", gap, exp_gap);
            chk(ulen == exp_len, "R10 serial update length", ulen, exp_len);
        end else begin
            chk(gap == exp_gap, "R9 parallel setup start", gap, exp_gap);
            chk(ulen == exp_len, "R9 parallel update length", ulen, exp_len);
        end
        chk(int'(active_core) == tgt, "R12 active core after handover", int'(active_core), tgt);
        chk(core_run == N'(1 << tgt), "R12 target runs", int'(core_run), 1 << tgt);
        chk(core_activate == '0, "R12 activate dropped", int'(core_activate), 0);
    endtask

    initial begin
        int src, tgt;
        rst = 1'b1; interval_en = 1'b0; interval_len = '0; ext_req = 1'b0;
        train_frac = 2'd0; serial_mode = 1'b0; wb_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(active_core == '0, "R1 reset active core", int'(active_core), 0);
        chk(core_run == N'(1), "R1 reset run enable", int'(core_run), 1);
        chk(!busy, "R1 reset busy", int'(busy), 0);
        chk((core_activate | core_train | core_flush | core_wb_req) == '0 && !reg_xfer_valid,
            "R1 reset strobes quiet", int'(core_activate | core_train | core_flush | core_wb_req), 0);
        src = 0;
        for (int i = 0; i < NV; i++) begin
            tgt = (src + 1) % N;
            migrate(VECS[i], src, tgt, 1'b0);
            src = tgt;
        end
        // R4: request held high across a whole migration
        tgt = (src + 1) % N;
        migrate('{1'b1, 16'd20, 2'd1, 1'b0, 8'd1}, src, tgt, 1'b1);
        ext_req = 1'b0;
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 30; k++) begin
                if (busy) extra++;
                @(negedge clk);
            end
            chk(extra == 0, "R4 held trigger ignored while busy", extra, 0);
            chk(int'(active_core) == tgt, "R4 single step", int'(active_core), tgt);
        end
        summary();
    end

endmodule